// File: doc/BRIEF.md
# GPIO Event Detect and Interrupt

This block watches a word of per-pin input data that has already been synchronised and polarity-adjusted upstream. For each pin it detects a configured event: either a high level, or an edge. It records every detection in a sticky status word and raises one interrupt line while any recorded event is also enabled. Because polarity is applied before this block, an inverted pin presents a physical falling transition as a rising one. Debounce filtering is handled upstream.

Software drives the block through a simple register write port. Separate registers select level or edge per pin, add falling-edge sensitivity, and hold the enable mask. The enable mask has set-only and clear-only aliases so that one pin's enable can change without a read-modify-write. Status bits are cleared by writing 1. A combinational read port returns the register contents. The write and read ports are plain control pins with no handshake: a write takes effect on every clock edge at which `wr_en` is high.

Top module: `evt_gpio_irq`

## Requirements
- R1: With a pin's kind bit at 0 (register code 0), a 1 on that pin's `din` bit during a cycle sets its status bit at that clock edge.
- R2: With the kind bit at 1, a 0-to-1 change of `din` against its value at the previous clock sets the status bit, whatever the both-edges bit (code 1) holds.
- R3: With the kind bit at 1, a 1-to-0 change sets the status bit only when the both-edges bit is 1. Otherwise it sets nothing.
- R4: Status bits (code 5) stay set until written with 1. A write to code 5 clears exactly the bits written as 1.
- R5: If a clearing write and a detection hit the same bit in the same cycle, the bit stays set. A level event whose input is still high therefore survives its clear.
- R6: `irq_o` is high exactly when some bit is set in both the status word and the enable word (code 2). It follows the registers with no added cycle.
- R7: A write to code 3 sets the enable bits written as 1, and a write to code 4 clears them. Other enable bits are kept. Codes 3 and 4 read back as 0.
- R8: A write to the kind, both-edges or enable register takes effect from the next cycle and implies no edge. Detection in the write cycle uses the old settings.
- R9: Reset clears kind, both-edges, enable and status, and holds `irq_o` low.
- R10: `rd_data` returns kind, both-edges, enable and status for codes 0, 1, 2 and 5. It returns 0 for any other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | PINS | Polarity-adjusted input data word |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register code for the write |
| wr_data | input | PINS | Write data |
| rd_sel | input | 3 | Register code for the read |
| rd_data | output | PINS | Read data for `rd_sel` |
| status_o | output | PINS | Sticky event status word |
| enable_o | output | PINS | Event enable word |
| irq_o | output | 1 | Interrupt request |

## Verification
The main function is driven with four kinds of input pattern, each meant to tell one mode from another:
- A held-high level on a level-mode pin separates level detection from edge detection. It also shows that the bit re-sets after a clear while the input stays high.
- Single rising and falling transitions on an edge-mode pin with the both-edges bit off, and then on a pin with it on, separate the three sensitivity settings.
- A level-mode pin is switched to edge mode, and back, while its input is held high. This shows that a configuration change is not mistaken for an edge and takes effect one cycle late.
- A wide word of sixteen simultaneously high upper pins, with only a high pin enabled through the set alias, shows that status and interrupt masking work across the full word.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_KIND   = 3'd0,
    REG_BOTH   = 3'd1,
    REG_EN     = 3'd2,
    REG_EN_SET = 3'd3,
    REG_EN_CLR = 3'd4,
    REG_STAT   = 3'd5
  } evt_reg_e;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import gpio_evt_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PINS-1:0]  wr_data,
  output logic [PINS-1:0]  kind_q,
  output logic [PINS-1:0]  both_q,
  output logic [PINS-1:0]  en_q
);
  logic sel_kind, sel_both, sel_en, sel_set, sel_clr;

  assign sel_kind = wr_en && (wr_sel == REG_KIND);
  assign sel_both = wr_en && (wr_sel == REG_BOTH);
  assign sel_en   = wr_en && (wr_sel == REG_EN);
  assign sel_set  = wr_en && (wr_sel == REG_EN_SET);
  assign sel_clr  = wr_en && (wr_sel == REG_EN_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= '0;
      both_q <= '0;
      en_q   <= '0;
    end else begin
      if (sel_kind) kind_q <= wr_data;
      if (sel_both) both_q <= wr_data;
      if (sel_en)
        en_q <= wr_data;
      else if (sel_set)
        en_q <= en_q | wr_data;
      else if (sel_clr)
        en_q <= en_q & ~wr_data;
    end
  end

  // R7
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_set |=> ((en_q & $past(wr_data)) == $past(wr_data)));

  // R7
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_clr |=> ((en_q & $past(wr_data)) == '0));

  // R7
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_set || sel_clr) |=> ((en_q & ~$past(wr_data)) == ($past(en_q) & ~$past(wr_data))));

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_en || sel_set || sel_clr) |=> $stable(en_q));
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] din,
  input  logic [PINS-1:0] kind,
  input  logic [PINS-1:0] both,
  output logic [PINS-1:0] hit
);
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic rise, fall;
    assign rise = din[g] & ~prev_q[g];
    assign fall = ~din[g] & prev_q[g];
    assign hit[g] = kind[g] ? (rise | (fall & both[g])) : din[g];
  end

  // R3
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((prev_q & ~din & kind & ~both) & hit) == '0));
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] hit,
  input  logic            clr_we,
  input  logic [PINS-1:0] clr_mask,
  input  logic [PINS-1:0] en,
  output logic [PINS-1:0] status_q,
  output logic            irq
);
  logic [PINS-1:0] eff_clr;

  assign eff_clr = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~eff_clr) | hit;
  end

  assign irq = |(status_q & en);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~status_q & $past(status_q & ~eff_clr)) == '0));

  // R5
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~status_q & $past(hit)) == '0));
endmodule

// File: rtl/evt_gpio_irq.sv
module evt_gpio_irq
  import gpio_evt_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  din,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PINS-1:0]  wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [PINS-1:0]  rd_data,
  output logic [PINS-1:0]  status_o,
  output logic [PINS-1:0]  enable_o,
  output logic             irq_o
);
  logic [PINS-1:0] kind_w, both_w, en_w, hit_w, stat_w;
  logic            irq_w, stat_we;

  assign stat_we = wr_en && (wr_sel == REG_STAT);

  evt_cfg_regs #(.PINS(PINS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .kind_q  (kind_w),
    .both_q  (both_w),
    .en_q    (en_w)
  );

  evt_edge_detect #(.PINS(PINS)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .kind  (kind_w),
    .both  (both_w),
    .hit   (hit_w)
  );

  evt_status #(.PINS(PINS)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit_w),
    .clr_we   (stat_we),
    .clr_mask (wr_data),
    .en       (en_w),
    .status_q (stat_w),
    .irq      (irq_w)
  );

  always_comb begin
    case (rd_sel)
      REG_KIND: rd_data = kind_w;
      REG_BOTH: rd_data = both_w;
      REG_EN:   rd_data = en_w;
      REG_STAT: rd_data = stat_w;
      default:  rd_data = '0;
    endcase
  end

  assign status_o = stat_w;
  assign enable_o = en_w;
  assign irq_o    = irq_w;

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((status_o & enable_o) != '0));
endmodule

// File: tb/evt_gpio_irq_test.sv
module evt_gpio_irq_test;
  import gpio_evt_pkg::*;

  localparam int PINS = 32;
  localparam int NV   = 25;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [31:0] din;
    logic [31:0] st;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'h6,        32'h0,        32'h0,        1'b0}, // R8 kind
    '{1'b1, 3'd1, 32'h4,        32'h0,        32'h0,        1'b0}, // R8 both
    '{1'b1, 3'd2, 32'h7,        32'h0,        32'h0,        1'b0}, // R6 enable
    '{1'b0, 3'd0, 32'h0,        32'h1,        32'h1,        1'b1}, // R1 level
    '{1'b1, 3'd5, 32'h1,        32'h1,        32'h1,        1'b1}, // R5 clear loses
    '{1'b0, 3'd0, 32'h0,        32'h0,        32'h1,        1'b1}, // R4 sticky
    '{1'b1, 3'd5, 32'h1,        32'h0,        32'h0,        1'b0}, // R4 clear
    '{1'b0, 3'd0, 32'h0,        32'h2,        32'h2,        1'b1}, // R2 rise
    '{1'b1, 3'd5, 32'h2,        32'h2,        32'h0,        1'b0}, // R2 no re-edge
    '{1'b0, 3'd0, 32'h0,        32'h0,        32'h0,        1'b0}, // R3 fall ignored
    '{1'b0, 3'd0, 32'h0,        32'h4,        32'h4,        1'b1}, // R2 rise with both
    '{1'b1, 3'd5, 32'h4,        32'h4,        32'h0,        1'b0}, // R4
    '{1'b0, 3'd0, 32'h0,        32'h0,        32'h4,        1'b1}, // R3 fall with both
    '{1'b1, 3'd4, 32'h4,        32'h0,        32'h4,        1'b0}, // R7 clear alias
    '{1'b1, 3'd3, 32'h4,        32'h0,        32'h4,        1'b1}, // R7 set alias
    '{1'b1, 3'd5, 32'h4,        32'h0,        32'h0,        1'b0}, // R4
    '{1'b0, 3'd0, 32'h0,        32'h8,        32'h8,        1'b0}, // R6 masked
    '{1'b1, 3'd0, 32'hE,        32'h8,        32'h8,        1'b0}, // R8 old kind
    '{1'b1, 3'd5, 32'h8,        32'h8,        32'h0,        1'b0}, // R8 no edge
    '{1'b1, 3'd0, 32'h6,        32'h8,        32'h0,        1'b0}, // R8 delayed
    '{1'b0, 3'd0, 32'h0,        32'h8,        32'h8,        1'b0}, // R8 level back
    '{1'b1, 3'd5, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0}, // R4 clear all
    '{1'b0, 3'd0, 32'h0,        32'hFFFF0000, 32'hFFFF0000, 1'b0}, // R1 wide
    '{1'b1, 3'd3, 32'h80000000, 32'hFFFF0000, 32'hFFFF0000, 1'b1}, // R6 R7
    '{1'b1, 3'd5, 32'hFFFFFFFF, 32'h0,        32'h0,        1'b0}  // R4
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [PINS-1:0]   din = '0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_sel = '0;
  logic [PINS-1:0]   wr_data = '0;
  logic [2:0]        rd_sel = '0;
  logic [PINS-1:0]   rd_data, status_o, enable_o;
  logic              irq_o;
  int                n_chk = 0;
  int                n_bad = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  evt_gpio_irq #(.PINS(PINS)) uut (
    .clk (clk), .rst_n (rst_n), .din (din),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_data (rd_data),
    .status_o (status_o), .enable_o (enable_o), .irq_o (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] s,
                      input logic [31:0] d, input logic [31:0] di);
    @(negedge clk);
    wr_en = w; wr_sel = s; wr_data = d; din = di;
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk("R9 status", status_o, 32'h0);
    chk("R9 enable", enable_o, 32'h0);
    chk("R9 irq", {31'b0, irq_o}, 32'h0);
    rd_sel = REG_KIND; #1 chk("R9 kind readback", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].sel, VECS[i].data, VECS[i].din);
      chk($sformatf("vector %0d status", i), status_o, VECS[i].st);
      chk($sformatf("vector %0d irq", i), {31'b0, irq_o}, {31'b0, VECS[i].irq});
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R10 readback
    rd_sel = REG_KIND;   #1 chk("R10 kind", rd_data, 32'h6);
    rd_sel = REG_BOTH;   #1 chk("R10 both", rd_data, 32'h4);
    rd_sel = REG_EN;     #1 chk("R10 enable", rd_data, 32'h80000007);
    rd_sel = REG_STAT;   #1 chk("R10 status", rd_data, 32'h0);
    // R7 aliases read as zero
    rd_sel = REG_EN_SET; #1 chk("R7 set alias read", rd_data, 32'h0);
    rd_sel = REG_EN_CLR; #1 chk("R7 clear alias read", rd_data, 32'h0);
    rd_sel = 3'd7;       #1 chk("R10 unused code", rd_data, 32'h0);

    // R1 R6: enabled level event then mid-run reset (R9)
    step(1'b0, 3'd0, 32'h0, 32'h1);
    chk("R1 level again", status_o, 32'h1);
    chk("R6 irq high", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    rst_n = 1'b0; din = '0;
    @(posedge clk);
    #5;
    chk("R9 status after reset", status_o, 32'h0);
    chk("R9 enable after reset", enable_o, 32'h0);
    chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);
    rd_sel = REG_BOTH; #1 chk("R9 both after reset", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    finish_run();
  end
endmodule